// File: doc/BRIEF.md
# Lockable Watchdog Timer

This block is a watchdog timer whose 24-bit time-out period sits in three byte registers (upper, high, low) behind a small byte-wide register port. The period registers are write-protected. Software opens them by writing a two-value key to the control address: first 8'h55, then 8'hAA. It must then write the three bytes in the fixed order upper, high, low. The write of the low byte closes access again.

A down-counter reloads from the period registers on reset, on every refresh strobe and after every time-out. When it expires, the action depends on the mode bit and on the stop-state input. In reset mode during normal running, the block pulses a system-reset request. In reset mode during stop, it pulses a stop-recovery request instead. In interrupt mode, it raises an interrupt request that stays high until it is acknowledged, and during stop it also pulses the stop-recovery request. Two sticky flags in the control register record the time-outs: one for any time-out, one for a time-out during stop. Reading the control register clears both.

Top module: `wdt_guard`

## Requirements
- R1: Write access to the period bytes opens only after 8'h55 and then 8'hAA are written to address 0. Any other control write, including one between the two key values, returns the key logic to its idle, locked state.
- R2: Control register (address 0) layout: bit 0 is the mode (1 = reset, 0 = interrupt, reset value 1), bit 5 reads 1 while access is open, bit 6 is the stop-time-out flag, bit 7 is the time-out flag, and the other bits read 0. Writes of 8'h55 or 8'hAA leave every control bit unchanged. Any other control write loads bit 0 from write-data bit 0.
- R3: While access is open, the period bytes are accepted only in the order upper (address 1), high (address 2), low (address 3). A write to any other period address is ignored. Writing the low byte closes access, and bit 5 then reads 0.
- R4: While access is closed, writes to addresses 1 to 3 do not change the period bytes, and the bytes read back unchanged.
- R5: The counter loads the period value P on reset, on a refresh and after each time-out. With no refresh, the time-out action appears on the outputs in the clock cycle after the P+1-th edge that follows the loading edge. A refresh pushes the next time-out back.
- R6: In reset mode with stop_in low, a time-out gives a one-cycle rst_req pulse and sets the time-out flag (bit 7).
- R7: In reset mode with stop_in high, a time-out gives a one-cycle stop_rec pulse and no rst_req.
- R8: In interrupt mode, a time-out raises irq and never rst_req. stop_rec pulses in the same cycle only when stop_in is high.
- R9: A time-out with stop_in high sets both bit 7 and bit 6. A read of address 0 (rd_en high) returns the flags and then clears them.
- R10: irq stays high until int_ack is asserted, and drops in the cycle after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register address: 0 control, 1 upper, 2 high, 3 low |
| wdata | input | 8 | Write data |
| we | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; on address 0 it clears the flags |
| rdata | output | 8 | Read data for addr |
| refresh | input | 1 | Reloads the counter |
| stop_in | input | 1 | High while the device is in the stop state |
| int_ack | input | 1 | Clears the interrupt request |
| irq | output | 1 | Interrupt request, held until acknowledged |
| rst_req | output | 1 | One-cycle system-reset request |
| stop_rec | output | 1 | One-cycle stop-recovery request |

## Verification
The bench builds the block with a reset period of 9 instead of the large default, so each time-out arrives within a few dozen cycles. This makes it possible to sweep every period value from 0 to 23 and measure each resulting time-out interval exactly. The short periods also let every combination of mode and stop state, the flag set-and-clear behaviour and the interrupt hold all be checked in one short run. The key sequence is tried in order, broken in the middle and followed by out-of-order byte writes, and every outcome is read back through the register port.

// File: rtl/wdt_guard.sv
module wdt_guard #(
  parameter logic [23:0] RELOAD_INIT = 24'h00FFFF,
  parameter bit          MODE_INIT   = 1'b1,
  parameter logic [7:0]  KEY_A       = 8'h55,
  parameter logic [7:0]  KEY_B       = 8'hAA
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  input  logic       we,
  input  logic       rd_en,
  output logic [7:0] rdata,
  input  logic       refresh,
  input  logic       stop_in,
  input  logic       int_ack,
  output logic       irq,
  output logic       rst_req,
  output logic       stop_rec
);

  typedef enum logic [2:0] {LOCKED, HALF, OPEN_U, OPEN_H, OPEN_L} key_t;

  key_t        st;
  logic [7:0]  ru, rh, rl;
  logic [23:0] cnt;
  logic        mode, to_flag, stop_flag;

  wire ctl_wr  = we && (addr == 2'd0);
  wire is_ka   = (wdata == KEY_A);
  wire is_kb   = (wdata == KEY_B);
  wire is_open = (st == OPEN_U) || (st == OPEN_H) || (st == OPEN_L);
  wire expired = !refresh && (cnt == 24'd0);
  wire ctl_rd  = rd_en && (addr == 2'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= LOCKED;
      ru <= RELOAD_INIT[23:16];
      rh <= RELOAD_INIT[15:8];
      rl <= RELOAD_INIT[7:0];
    end else if (ctl_wr) begin
      if (is_ka)                   st <= HALF;
      else if (is_kb && st == HALF) st <= OPEN_U;
      else                         st <= LOCKED;
    end else if (we) begin
      case (addr)
        2'd1: if (st == OPEN_U) begin ru <= wdata; st <= OPEN_H; end
        2'd2: if (st == OPEN_H) begin rh <= wdata; st <= OPEN_L; end
        2'd3: if (st == OPEN_L) begin rl <= wdata; st <= LOCKED; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      mode <= MODE_INIT;
    else if (ctl_wr && !is_ka && !is_kb) mode <= wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= RELOAD_INIT;
    else if (refresh || expired) cnt <= {ru, rh, rl};
    else                        cnt <= cnt - 24'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req   <= 1'b0;
      stop_rec  <= 1'b0;
      irq       <= 1'b0;
      to_flag   <= 1'b0;
      stop_flag <= 1'b0;
    end else begin
      rst_req  <= expired && mode && !stop_in;
      stop_rec <= expired && stop_in;
      if (expired && !mode) irq <= 1'b1;
      else if (int_ack)     irq <= 1'b0;
      if (expired)     to_flag <= 1'b1;
      else if (ctl_rd) to_flag <= 1'b0;
      if (expired && stop_in) stop_flag <= 1'b1;
      else if (ctl_rd)        stop_flag <= 1'b0;
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = {to_flag, stop_flag, is_open, 4'b0000, mode};
      2'd1:    rdata = ru;
      2'd2:    rdata = rh;
      default: rdata = rl;
    endcase
  end

endmodule

module wdt_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       we,
  input logic       stop_in,
  input logic       int_ack,
  input logic       irq,
  input logic       rst_req,
  input logic       stop_rec,
  input logic [7:0] ru,
  input logic [7:0] rh,
  input logic [7:0] rl,
  input logic       to_flag,
  input logic       stop_flag
);
  AST_RELOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !we |=> $stable({ru, rh, rl})); // R4
  AST_RST_NOT_STOP: assert property (@(posedge clk) disable iff (!rst_n) rst_req |-> !$past(stop_in)); // R6
  AST_REC_IN_STOP:  assert property (@(posedge clk) disable iff (!rst_n) stop_rec |-> $past(stop_in)); // R7
  AST_ONE_ACTION:   assert property (@(posedge clk) disable iff (!rst_n) !(rst_req && stop_rec)); // R7
  AST_STOP_FLAGS:   assert property (@(posedge clk) disable iff (!rst_n) stop_rec |-> (to_flag && stop_flag)); // R9
  AST_IRQ_HOLD:     assert property (@(posedge clk) disable iff (!rst_n) (irq && !int_ack) |=> irq); // R10
  AST_IRQ_DROP:     assert property (@(posedge clk) disable iff (!rst_n) ($fell(irq)) |-> $past(int_ack)); // R10
endmodule

bind wdt_guard wdt_guard_chk u_chk (.*);

// File: tb/wdt_guard_test.sv
module wdt_guard_test;
  logic       clk = 0, rst_n = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic       we = 0, rd_en = 0, refresh = 0, stop_in = 0, int_ack = 0;
  logic [7:0] rdata;
  logic       irq, rst_req, stop_rec;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wdt_guard #(.RELOAD_INIT(24'd9)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we), .rd_en(rd_en),
    .rdata(rdata), .refresh(refresh), .stop_in(stop_in), .int_ack(int_ack),
    .irq(irq), .rst_req(rst_req), .stop_rec(stop_rec));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic set_reload(input logic [23:0] p);
    wr(0, 8'h55); wr(0, 8'hAA);
    wr(1, p[23:16]); wr(2, p[15:8]); wr(3, p[7:0]);
  endtask

  // sel: 0 rst_req, 1 stop_rec, 2 irq. n counts negedges after the loading edge's window.
  task automatic measure(input int sel, output int n, output bit s_rst, output bit s_rec);
    bit hit;
    @(negedge clk); refresh = 1; int_ack = 1;
    @(negedge clk); refresh = 0; int_ack = 0;
    n = 1; s_rst = 0; s_rec = 0; hit = 0;
    while (!hit && n < 300) begin
      s_rst |= rst_req; s_rec |= stop_rec;
      hit = (sel == 0) ? rst_req : (sel == 1) ? stop_rec : irq;
      if (!hit) begin @(negedge clk); n++; end
    end
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int n; bit sr, sc;
    repeat (3) @(negedge clk);
    rst_n = 1;
    addr = 0; #1 chk("R2 reset ctrl", rdata, 8'h01);
    rd(1, d); chk("R5 reset upper", d, 0);
    rd(2, d); chk("R5 reset high", d, 0);
    rd(3, d); chk("R5 reset low", d, 9);
    measure(0, n, sr, sc); chk("R5 R6 initial period", n, 11);

    wr(1, 8'h33); wr(2, 8'h33); wr(3, 8'h33);
    rd(1, d); chk("R4 locked upper", d, 0);
    rd(2, d); chk("R4 locked high", d, 0);
    rd(3, d); chk("R4 locked low", d, 9);
    measure(0, n, sr, sc); chk("R4 period kept", n, 11);

    wr(0, 8'h55); wr(0, 8'hAA);
    addr = 0; #1 chk("R1 R2 open, mode kept", rdata & 8'h3F, 8'h21);
    wr(2, 8'h05); rd(2, d); chk("R3 out of order high", d, 0);
    wr(3, 8'h05); rd(3, d); chk("R3 out of order low", d, 9);
    wr(1, 8'h00); wr(2, 8'h00); wr(3, 8'h0C);
    rd(3, d); chk("R3 ordered low", d, 12);
    addr = 0; #1 chk("R3 relocked", rdata & 8'h3F, 8'h01);

    wr(0, 8'h55); wr(0, 8'h03); wr(0, 8'hAA); wr(1, 8'h07);
    rd(1, d); chk("R1 broken key", d, 0);
    wr(0, 8'h55); wr(0, 8'h55); wr(0, 8'hAA); wr(1, 8'h00);
    addr = 0; #1 chk("R1 repeat first key", rdata & 8'h3F, 8'h21);
    wr(2, 8'h00); wr(3, 8'h0C);
    wr(0, 8'h02); addr = 0; #1 chk("R2 mode write", rdata & 8'h01, 0);
    wr(0, 8'h01); addr = 0; #1 chk("R2 mode write back", rdata & 8'h01, 1);

    for (int p = 0; p < 24; p++) begin
      set_reload(24'(p));
      measure(0, n, sr, sc);
      chk($sformatf("R5 sweep period %0d", p), n, p + 2);
    end
    set_reload(24'h010203);
    rd(1, d); chk("R3 upper byte", d, 1);
    rd(2, d); chk("R3 high byte", d, 2);
    rd(3, d); chk("R3 low byte", d, 3);

    set_reload(24'd30);
    rd(0, d);
    measure(0, n, sr, sc); chk("R6 reset pulse", n, 32);
    @(negedge clk); chk("R6 one cycle", rst_req, 0);
    rd(0, d); chk("R6 status flag", d, 8'h81);

    stop_in = 1;
    rd(0, d);
    measure(1, n, sr, sc); chk("R7 stop recovery", n, 32);
    chk("R7 no reset in stop", sr, 0);
    rd(0, d); chk("R9 both flags", d, 8'hC1);
    rd(0, d); chk("R9 cleared by read", d, 8'h01);

    wr(0, 8'h00);
    measure(2, n, sr, sc); chk("R8 irq in stop", n, 32);
    chk("R8 stop_rec with irq", sc, 1);
    chk("R8 no reset", sr, 0);
    stop_in = 0;
    measure(2, n, sr, sc); chk("R8 irq normal", n, 32);
    chk("R8 no stop_rec normal", sc, 0);
    chk("R8 no reset normal", sr, 0);
    repeat (40) @(negedge clk);
    chk("R10 irq held", irq, 1);
    int_ack = 1; @(negedge clk); int_ack = 0;
    chk("R10 irq dropped", irq, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule